// File: doc/BRIEF.md
# Serial Converter Output Port

This block is the digital side of a serial-output sampling converter. A host drives two slow pins: a conversion strobe and a serial clock. Both are sampled by a fast system clock through synchronizers, and every later decision is counted in detected rising edges. A strobe edge opens a frame and latches the parallel word from the conversion source. The word then leaves MSB first on the serial data line, one bit per serial-clock edge, after a short lead-in. The data line has an output enable, and that enable is low whenever no bit is being sent.

The same strobe pin also carries power-down requests. Strobe edges that arrive with no serial-clock edge between them are counted. A short run of them puts the block in a light low-power state, and a longer run puts it in a deep one. Any serial-clock edge brings it back to active. The power state and a frame-busy flag are brought out on ports.

Top module: `sadc_link`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `frame_active_o` is 0 and `power_state_o` is 2'b00 (active), including when reset arrives in the middle of a frame.
- R2: A detected rising edge of `conv_i` while no frame is active raises `frame_active_o` and latches `sample_i`, and `sdo_oe_o` is 0 at that point.
- R3: While a frame is active, further `conv_i` rising edges neither restart the frame nor change `sdo_o`/`sdo_oe_o`.
- R4: The enable stays 0 after the 1st and 2nd `sck_i` rising edges of a frame. The latched word's MSB is driven after the 3rd edge, and each later edge moves to the next lower bit, so bit DATA_W-k is sent after edge k+2.
- R5: After the edge that follows the last data bit (the 17th with 14 bits), `sdo_oe_o` returns to 0 and stays 0 on further `sck_i` edges until a new frame begins. `sdo_o` reads 0 while disabled.
- R6: `frame_active_o` drops at the 16th `sck_i` rising edge of a frame. A `conv_i` edge after that point opens a new frame at once.
- R7: Two `conv_i` rising edges with no `sck_i` rising edge between them set `power_state_o` to 2'b01 (nap). A single such edge leaves it at 2'b00, and three edges keep it at 2'b01.
- R8: Four or more such edges set `power_state_o` to 2'b10 (sleep), and further strobes keep it there. The value 2'b11 never appears.
- R9: Any `sck_i` rising edge returns `power_state_o` to 2'b00 on the next cycle.
- R10: `sdo_o` and `sdo_oe_o` change only on a detected `sck_i` rising edge or a frame start, so each bit holds until the next serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion strobe pin, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| sample_i | input | DATA_W | Parallel word from the conversion source |
| sdo_o | output | 1 | Serial data bit, 0 while disabled |
| sdo_oe_o | output | 1 | Output enable for the data pad, 0 means high impedance |
| power_state_o | output | 2 | 00 active, 01 nap, 10 sleep |
| frame_active_o | output | 1 | High from frame start to the 16th serial-clock edge |

## Verification
The bench uses the defaults: a 14-bit word, a two-edge lead-in, a 16-edge frame, and nap and sleep thresholds of two and four strobes. With these values the last data bit falls on the same edge where the frame closes. That makes it possible to check the gap in which a new strobe is accepted while the previous bit is still on the pin. The four-strobe sleep threshold is reached within a handful of pulses, so saturation and wake-up from both low-power states are exercised as well.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'b00,
        PWR_NAP    = 2'b01,
        PWR_SLEEP  = 2'b10
    } pwr_e;

endpackage

// File: rtl/sadc_edge_sync.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module sadc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/sadc_frame.sv
// Frame tracker: counts serial-clock edges after a start strobe, shifts the
// latched word out MSB first and controls the pad enable.
module sadc_frame #(
    parameter int DATA_W      = 14,
    parameter int LEAD_EDGES  = 2,
    parameter int FRAME_EDGES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_rise_i,
    input  logic              sck_rise_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              frame_active_o,
    output logic              frame_start_o
);

    localparam int CNT_W = $clog2(FRAME_EDGES + 2);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(FRAME_EDGES);
    localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(LEAD_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(LEAD_EDGES + DATA_W);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              oe;
    } frame_st_t;

    frame_st_t        st_d, st_q;
    logic [CNT_W-1:0] cnt_n;
    logic             start;

    always_comb begin
        st_d  = st_q;
        cnt_n = st_q.cnt;
        start = conv_rise_i & ~st_q.active;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shreg  = sample_i;
            st_d.oe     = 1'b0;
        end else if (sck_rise_i) begin
            if (st_q.cnt != CNT_SAT) begin
                cnt_n = st_q.cnt + 1'b1;
            end
            st_d.cnt = cnt_n;
            if (st_q.active && (cnt_n == CNT_END)) begin
                st_d.active = 1'b0;
            end
            st_d.oe = (cnt_n >= FIRST_BIT) && (cnt_n <= LAST_BIT);
            if ((cnt_n > FIRST_BIT) && (cnt_n <= LAST_BIT)) begin
                st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cnt    <= CNT_SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_start_o  = start;
    assign frame_active_o = st_q.active;
    assign sdo_oe_o       = st_q.oe;
    assign sdo_o          = st_q.oe & st_q.shreg[DATA_W-1];

endmodule

// File: rtl/sadc_power.sv
// Power-state decoder: counts strobe edges with no serial-clock edge between.
module sadc_power
    import sadc_pkg::*;
#(
    parameter int NAP_EDGES   = 2,
    parameter int SLEEP_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_rise_i,
    input  logic       sck_rise_i,
    output logic [1:0] power_state_o
);

    localparam int RUN_W = $clog2(SLEEP_EDGES + 1);
    localparam logic [RUN_W-1:0] RUN_NAP   = RUN_W'(NAP_EDGES);
    localparam logic [RUN_W-1:0] RUN_SLEEP = RUN_W'(SLEEP_EDGES);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        pwr_e             state;
    } pwr_st_t;

    pwr_st_t          st_d, st_q;
    logic [RUN_W-1:0] run_n;

    always_comb begin
        st_d  = st_q;
        run_n = st_q.run;
        if (sck_rise_i) begin
            run_n = '0;
        end
        if (conv_rise_i && (run_n != RUN_SLEEP)) begin
            run_n = run_n + 1'b1;
        end
        st_d.run = run_n;
        if (run_n >= RUN_SLEEP) begin
            st_d.state = PWR_SLEEP;
        end else if (run_n >= RUN_NAP) begin
            st_d.state = PWR_NAP;
        end else begin
            st_d.state = PWR_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run   <= '0;
            st_q.state <= PWR_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign power_state_o = st_q.state;

endmodule

// File: rtl/sadc_link.sv
module sadc_link #(
    parameter int DATA_W      = 14,
    parameter int LEAD_EDGES  = 2,
    parameter int FRAME_EDGES = 16,
    parameter int NAP_EDGES   = 2,
    parameter int SLEEP_EDGES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_i,
    input  logic              sck_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [1:0]        power_state_o,
    output logic              frame_active_o
);

    localparam int N_PINS = 2;

    logic [N_PINS-1:0] pin_raw;
    logic [N_PINS-1:0] pin_rise;
    logic              conv_rise;
    logic              sck_rise;
    logic              frame_start;

    assign pin_raw   = {sck_i, conv_i};
    assign conv_rise = pin_rise[0];
    assign sck_rise  = pin_rise[1];

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        sadc_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (pin_raw[g]),
            .rise_o (pin_rise[g])
        );
    end

    sadc_frame #(
        .DATA_W      (DATA_W),
        .LEAD_EDGES  (LEAD_EDGES),
        .FRAME_EDGES (FRAME_EDGES)
    ) i_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_rise_i    (conv_rise),
        .sck_rise_i     (sck_rise),
        .sample_i       (sample_i),
        .sdo_o          (sdo_o),
        .sdo_oe_o       (sdo_oe_o),
        .frame_active_o (frame_active_o),
        .frame_start_o  (frame_start)
    );

    sadc_power #(
        .NAP_EDGES   (NAP_EDGES),
        .SLEEP_EDGES (SLEEP_EDGES)
    ) i_power (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_rise_i   (conv_rise),
        .sck_rise_i    (sck_rise),
        .power_state_o (power_state_o)
    );

endmodule

// File: rtl/sadc_link_chk.sv
module sadc_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_rise,
    input logic       sck_rise,
    input logic       frame_start,
    input logic       sdo_o,
    input logic       sdo_oe_o,
    input logic [1:0] power_state_o,
    input logic       frame_active_o
);

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active_o && conv_rise) |=> (frame_active_o && !sdo_oe_o)); // R2

    AST_CONV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active_o && conv_rise && !sck_rise) |=> (frame_active_o && $stable(sdo_oe_o) && $stable(sdo_o))); // R3

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> !sdo_o); // R5

    AST_NO_DIRECT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (power_state_o == 2'b00 && conv_rise && !sck_rise) |=> (power_state_o != 2'b10)); // R7

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (power_state_o == 2'b10 && !sck_rise) |=> (power_state_o == 2'b10)); // R8

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        power_state_o != 2'b11); // R8

    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> (power_state_o == 2'b00)); // R9

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !frame_start) |=> ($stable(sdo_o) && $stable(sdo_oe_o))); // R10

endmodule

bind sadc_link sadc_link_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .conv_rise      (conv_rise),
    .sck_rise       (sck_rise),
    .frame_start    (frame_start),
    .sdo_o          (sdo_o),
    .sdo_oe_o       (sdo_oe_o),
    .power_state_o  (power_state_o),
    .frame_active_o (frame_active_o)
);

// File: tb/test_sadc_link.sv
module test_sadc_link;

    localparam int DW   = 14;
    localparam int NVEC = 6;

    // Stimulus table: sample word and the SCK edge after which an extra
    // strobe is injected (0 = none).
    localparam logic [DW-1:0] VEC_SAMPLE [NVEC] = '{
        14'h3FFF, 14'h0000, 14'h2AAA, 14'h1555, 14'h2001, 14'h1234
    };
    localparam int VEC_CONV_AT [NVEC] = '{0, 2, 5, 0, 15, 9};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_i = 1'b0;
    logic          sck_i = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          sdo_o;
    logic          sdo_oe_o;
    logic [1:0]    power_state_o;
    logic          frame_active_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sadc_link i_sadc_link (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_i         (conv_i),
        .sck_i          (sck_i),
        .sample_i       (sample_i),
        .sdo_o          (sdo_o),
        .sdo_oe_o       (sdo_oe_o),
        .power_state_o  (power_state_o),
        .frame_active_o (frame_active_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic conv_pulse();
        conv_i = 1'b1; settle();
        conv_i = 1'b0; settle();
    endtask

    task automatic sck_pulse();
        sck_i = 1'b1; settle();
        sck_i = 1'b0; settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset oe", sdo_oe_o, 0);
        chk("R1 reset frame", frame_active_o, 0);
        chk("R1 reset power", power_state_o, 2'b00);
        rst_n = 1'b1;
        settle();
        // idle serial clocks must not enable the pad
        sck_pulse(); sck_pulse(); sck_pulse();
        chk("R5 idle sck oe", sdo_oe_o, 0);

        // table-driven frames
        for (int v = 0; v < NVEC; v++) begin
            logic [DW-1:0] s;
            s = VEC_SAMPLE[v];
            sample_i = s;
            conv_pulse();
            sample_i = ~s;
            chk("R2 frame start", frame_active_o, 1);
            chk("R2 oe low at start", sdo_oe_o, 0);
            for (int k = 1; k <= 17; k++) begin
                logic exp_oe;
                logic hi_bit;
                logic hi_oe;
                exp_oe = (k >= 3) && (k <= 16);
                sck_i = 1'b1; settle();
                hi_bit = sdo_o;
                hi_oe  = sdo_oe_o;
                sck_i = 1'b0; settle();
                chk("R10 bit held over sck low", {hi_oe, hi_bit}, {sdo_oe_o, sdo_o});
                chk(exp_oe ? "R4 oe during data" : "R5 oe outside data", sdo_oe_o, exp_oe);
                if (exp_oe) chk("R4 data bit", sdo_o, s[16-k]);
                else        chk("R5 sdo low while off", sdo_o, 0);
                chk("R6 frame flag", frame_active_o, (k < 16));
                if (k == VEC_CONV_AT[v]) begin
                    logic b_oe;
                    logic b_bit;
                    b_oe  = sdo_oe_o;
                    b_bit = sdo_o;
                    conv_pulse();
                    chk("R3 extra strobe frame", frame_active_o, 1);
                    chk("R3 extra strobe pin", {sdo_oe_o, sdo_o}, {b_oe, b_bit});
                end
            end
            chk("R9 power after frame", power_state_o, 2'b00);
        end

        // R6: strobe after the 16th edge opens a new frame at once
        sample_i = 14'h2C3A;
        conv_pulse();
        for (int k = 1; k <= 16; k++) sck_pulse();
        chk("R6 frame closed at 16", frame_active_o, 0);
        chk("R6 last bit still out", sdo_oe_o, 1);
        conv_pulse();
        chk("R6 restart frame", frame_active_o, 1);
        chk("R6 restart oe low", sdo_oe_o, 0);
        for (int k = 1; k <= 17; k++) sck_pulse();
        chk("R6 restarted frame done", frame_active_o, 0);

        // R7/R8/R9: power requests
        conv_pulse();
        chk("R7 one strobe stays active", power_state_o, 2'b00);
        conv_pulse();
        chk("R7 two strobes nap", power_state_o, 2'b01);
        conv_pulse();
        chk("R7 three strobes nap", power_state_o, 2'b01);
        conv_pulse();
        chk("R8 four strobes sleep", power_state_o, 2'b10);
        conv_pulse();
        conv_pulse();
        chk("R8 sleep saturates", power_state_o, 2'b10);
        sck_pulse();
        chk("R9 wake from sleep", power_state_o, 2'b00);
        for (int k = 2; k <= 17; k++) sck_pulse();
        chk("R6 frame done after wake", frame_active_o, 0);

        conv_pulse();
        conv_pulse();
        chk("R7 nap again", power_state_o, 2'b01);
        sck_pulse();
        chk("R9 wake from nap", power_state_o, 2'b00);
        for (int k = 2; k <= 17; k++) sck_pulse();

        // R1: reset in the middle of a data phase
        sample_i = 14'h3FFF;
        conv_pulse();
        for (int k = 1; k <= 5; k++) sck_pulse();
        chk("R4 mid frame oe", sdo_oe_o, 1);
        conv_pulse();
        conv_pulse();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset oe", sdo_oe_o, 0);
        chk("R1 mid reset frame", frame_active_o, 0);
        chk("R1 mid reset power", power_state_o, 2'b00);
        rst_n = 1'b1;
        settle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule